// File: doc/BRIEF.md
# Multiplicative Segment ID Scrambler

This block turns a proto segment identifier into a virtual segment identifier through a one-to-one scramble. The scramble multiplies the proto ID by a fixed prime and reduces the product modulo 2^n − 1. It does this with no divider. The product is folded once (high half plus low half), and an end-around carry then finishes the reduction. A mode bit selects the segment size, and with it both the multiplier and the modulus width. The large-segment mode uses a 24-bit modulus and the prime 12538073. The small-segment mode uses a 36-bit modulus and the prime 200730139.

The block also builds the proto ID itself, from a context number and the upper effective-address bits. For a user address, the context is placed above a short field of segment-number bits. For a kernel address, the segment number is used directly and the context plays no part. The input side has a valid/ready pair. The output appears a fixed three cycles after an input is accepted, and one input can be taken every cycle. The value with all bits set is reserved. A proto ID equal to it raises an error flag alongside its result.

Top module: `vsid_scrambler`

## Requirements
- R1: While reset is asserted, out_valid, out_err and in_ready are 0. in_ready rises no more than three clock edges after reset is released.
- R2: With in_mode=0 (256 MB segments, n=36), out_vsid equals proto × 200730139 mod (2^36 − 1), taken over 36 bits.
- R3: With in_mode=1 (1 TB segments, n=24), out_vsid equals proto × 12538073 mod (2^24 − 1), and out_vsid bits 35:24 are 0.
- R4: A user address (in_user=1) in mode 0 gives proto = in_ctx × 2^16 + in_ea_seg[15:0]. in_ea_seg[35:16] has no effect.
- R5: A user address in mode 1 gives proto = in_ctx × 2^4 + in_ea_seg[15:12].
- R6: A kernel address (in_user=0) gives proto = in_ea_seg[35:0] in mode 0 and in_ea_seg[35:12] in mode 1. in_ctx has no effect on it.
- R7: An input is accepted on a rising edge where in_valid and in_ready are both 1. Its result shows with out_valid=1 after the third rising edge, counting the accepting edge as the first. One input can be accepted on every edge, and the results come out in order.
- R8: When the proto ID equals 2^n − 1, out_err=1 and out_vsid=0. Otherwise out_err=0, and out_vsid never equals 2^n − 1.
- R9: An edge with in_valid=0, or with in_ready=0, produces no output: three edges later, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input request valid |
| in_ready | output | 1 | Block can take an input (high once out of reset) |
| in_mode | input | 1 | Segment size: 0 = 256 MB (n=36), 1 = 1 TB (n=24) |
| in_user | input | 1 | 1 = user address (context used), 0 = kernel address |
| in_ctx | input | 19 | Context number |
| in_ea_seg | input | 36 | Effective address bits 63:28 |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Proto ID was the reserved all-ones value |
| out_vsid | output | 36 | Scrambled segment ID (upper 12 bits zero in mode 1) |

## Verification
On every cycle, the bound checker verifies several properties. It checks the three-edge link between acceptance and out_valid, and that the reserved result never leaves the block. It checks that an error always comes with a zero result, and that the upper bits are clear in 1 TB mode. It also checks the bound on the folded sum that lets a single carry step finish the reduction. The bench's directed scenarios are what show the arithmetic itself. They compare each result with a true modulo of the full product for both multipliers. They also cover the proto formation for user and kernel addresses, that out-of-field address and context bits are ignored, and mixed-mode back-to-back streams with gaps.

// File: rtl/vsid_pkg.sv
`timescale 1ns/1ps
package vsid_pkg;

  // segment-size selector shared by all stages
  typedef enum logic {
    SEG_256M = 1'b0,
    SEG_1T   = 1'b1
  } seg_mode_e;

  // default geometry
  localparam int unsigned DEF_CTX_W   = 19;
  localparam int unsigned DEF_SEG_W   = 36;          // EA bits 63:28
  localparam int unsigned DEF_NB_S    = 36;          // modulus width, small segments
  localparam int unsigned DEF_NB_L    = 24;          // modulus width, large segments
  localparam int unsigned DEF_MUL_W   = 28;
  localparam int unsigned DEF_MUL_S   = 200730139;
  localparam int unsigned DEF_MUL_L   = 12538073;
  localparam int unsigned DEF_UBITS_S = 16;          // user segment-number bits, small
  localparam int unsigned DEF_UBITS_L = 4;           // user segment-number bits, large
  localparam int unsigned DEF_LSHIFT  = 12;          // large segment number offset in seg field

endpackage

// File: rtl/vsid_rst_sync.sv
`timescale 1ns/1ps
module vsid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/vsid_proto.sv
`timescale 1ns/1ps
module vsid_proto
  import vsid_pkg::*;
#(
  parameter int unsigned CTX_W   = DEF_CTX_W,
  parameter int unsigned SEG_W   = DEF_SEG_W,
  parameter int unsigned NB_S    = DEF_NB_S,
  parameter int unsigned NB_L    = DEF_NB_L,
  parameter int unsigned UBITS_S = DEF_UBITS_S,
  parameter int unsigned UBITS_L = DEF_UBITS_L,
  parameter int unsigned LSHIFT  = DEF_LSHIFT
) (
  input  seg_mode_e         mode,
  input  logic              user,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [SEG_W-1:0]  ea_seg,
  output logic [NB_S-1:0]   proto,
  output logic              reserved
);

  logic [NB_S-1:0] proto_s;
  logic [NB_L-1:0] proto_l;

  always_comb begin
    proto_s = '0;
    proto_l = '0;
    if (user) begin
      proto_s[UBITS_S-1:0]     = ea_seg[UBITS_S-1:0];
      proto_s[UBITS_S +: CTX_W] = ctx;
      proto_l[UBITS_L-1:0]     = ea_seg[LSHIFT +: UBITS_L];
      proto_l[UBITS_L +: CTX_W] = ctx;
    end else begin
      proto_s = ea_seg[NB_S-1:0];
      proto_l = ea_seg[LSHIFT +: NB_L];
    end
  end

  always_comb begin
    if (mode == SEG_1T) begin
      proto    = NB_S'(proto_l);
      reserved = (proto_l == {NB_L{1'b1}});
    end else begin
      proto    = proto_s;
      reserved = (proto_s == {NB_S{1'b1}});
    end
  end

endmodule

// File: rtl/vsid_mul_stage.sv
`timescale 1ns/1ps
module vsid_mul_stage
  import vsid_pkg::*;
#(
  parameter int unsigned NB_S  = DEF_NB_S,
  parameter int unsigned MUL_W = DEF_MUL_W,
  parameter int unsigned MUL_S = DEF_MUL_S,
  parameter int unsigned MUL_L = DEF_MUL_L,
  localparam int unsigned PROD_W = NB_S + MUL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  seg_mode_e         mode_i,
  input  logic              err_i,
  input  logic [NB_S-1:0]   proto_i,
  output logic              v_o,
  output seg_mode_e         mode_o,
  output logic              err_o,
  output logic [PROD_W-1:0] prod_o
);

  localparam logic [MUL_W-1:0] K_S = MUL_W'(MUL_S);
  localparam logic [MUL_W-1:0] K_L = MUL_W'(MUL_L);

  logic [MUL_W-1:0]  k_sel;
  logic [PROD_W-1:0] prod_d;
  logic              v_q;
  seg_mode_e         mode_q;
  logic              err_q;
  logic [PROD_W-1:0] prod_q;

  always_comb begin
    k_sel  = (mode_i == SEG_1T) ? K_L : K_S;
    prod_d = PROD_W'(proto_i) * PROD_W'(k_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      mode_q <= mode_i;
      err_q  <= err_i;
      prod_q <= prod_d;
    end
  end

  assign v_o    = v_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;
  assign prod_o = prod_q;

endmodule

// File: rtl/vsid_fold_stage.sv
`timescale 1ns/1ps
module vsid_fold_stage
  import vsid_pkg::*;
#(
  parameter int unsigned NB_S  = DEF_NB_S,
  parameter int unsigned NB_L  = DEF_NB_L,
  parameter int unsigned MUL_W = DEF_MUL_W,
  localparam int unsigned PROD_W = NB_S + MUL_W,
  localparam int unsigned FOLD_W = NB_S + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  seg_mode_e         mode_i,
  input  logic              err_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic              v_o,
  output seg_mode_e         mode_o,
  output logic              err_o,
  output logic [FOLD_W-1:0] fold_o
);

  logic [FOLD_W-1:0] fold_d;
  logic              v_q;
  seg_mode_e         mode_q;
  logic              err_q;
  logic [FOLD_W-1:0] fold_q;

  // one fold: high part above the modulus width added to the low part
  always_comb begin
    if (mode_i == SEG_1T)
      fold_d = FOLD_W'(prod_i[NB_L +: NB_L]) + FOLD_W'(prod_i[NB_L-1:0]);
    else
      fold_d = FOLD_W'(prod_i[PROD_W-1:NB_S]) + FOLD_W'(prod_i[NB_S-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      mode_q <= mode_i;
      err_q  <= err_i;
      fold_q <= fold_d;
    end
  end

  assign v_o    = v_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;
  assign fold_o = fold_q;

endmodule

// File: rtl/vsid_fix_stage.sv
`timescale 1ns/1ps
module vsid_fix_stage
  import vsid_pkg::*;
#(
  parameter int unsigned NB_S = DEF_NB_S,
  parameter int unsigned NB_L = DEF_NB_L,
  localparam int unsigned FOLD_W = NB_S + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  seg_mode_e         mode_i,
  input  logic              err_i,
  input  logic [FOLD_W-1:0] fold_i,
  output logic              v_o,
  output seg_mode_e         mode_o,
  output logic              err_o,
  output logic [NB_S-1:0]   vsid_o
);

  logic            carry_s;
  logic            carry_l;
  logic [NB_S-1:0] res_s;
  logic [NB_L-1:0] res_l;
  logic [NB_S-1:0] vsid_d;
  logic            v_q;
  seg_mode_e       mode_q;
  logic            err_q;
  logic [NB_S-1:0] vsid_q;

  // end-around carry: set when the folded value is at or above 2^n - 1,
  // which equals bit n of (fold + 1) given the fold bound
  always_comb begin
    carry_s = fold_i[NB_S] | (&fold_i[NB_S-1:0]);
    carry_l = fold_i[NB_L] | (&fold_i[NB_L-1:0]);
    res_s   = fold_i[NB_S-1:0] + NB_S'(carry_s);
    res_l   = fold_i[NB_L-1:0] + NB_L'(carry_l);
    vsid_d  = (mode_i == SEG_1T) ? NB_S'(res_l) : res_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      mode_q <= mode_i;
      err_q  <= err_i;
      vsid_q <= vsid_d;
    end
  end

  assign v_o    = v_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;
  assign vsid_o = vsid_q;

endmodule

// File: rtl/vsid_scrambler.sv
`timescale 1ns/1ps
module vsid_scrambler
  import vsid_pkg::*;
#(
  parameter int unsigned CTX_W   = DEF_CTX_W,
  parameter int unsigned SEG_W   = DEF_SEG_W,
  parameter int unsigned NB_S    = DEF_NB_S,
  parameter int unsigned NB_L    = DEF_NB_L,
  parameter int unsigned MUL_W   = DEF_MUL_W,
  parameter int unsigned MUL_S   = DEF_MUL_S,
  parameter int unsigned MUL_L   = DEF_MUL_L,
  parameter int unsigned UBITS_S = DEF_UBITS_S,
  parameter int unsigned UBITS_L = DEF_UBITS_L,
  parameter int unsigned LSHIFT  = DEF_LSHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_mode,
  input  logic             in_user,
  input  logic [CTX_W-1:0] in_ctx,
  input  logic [SEG_W-1:0] in_ea_seg,
  output logic             out_valid,
  output logic             out_err,
  output logic [NB_S-1:0]  out_vsid
);

  localparam int unsigned PROD_W = NB_S + MUL_W;
  localparam int unsigned FOLD_W = NB_S + 1;

  logic              rst_int_n;
  logic              accept;
  seg_mode_e         mode0;
  logic [NB_S-1:0]   proto0;
  logic              rsv0;

  logic              v1, err1;
  seg_mode_e         mode1;
  logic [PROD_W-1:0] prod1;
  logic              v2, err2;
  seg_mode_e         mode2;
  logic [FOLD_W-1:0] fold2;
  logic              v3, err3;
  seg_mode_e         mode3;
  logic [NB_S-1:0]   vsid3;

  vsid_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign in_ready = rst_int_n;
  assign accept   = in_valid & rst_int_n;
  assign mode0    = seg_mode_e'(in_mode);

  vsid_proto #(
    .CTX_W(CTX_W), .SEG_W(SEG_W), .NB_S(NB_S), .NB_L(NB_L),
    .UBITS_S(UBITS_S), .UBITS_L(UBITS_L), .LSHIFT(LSHIFT)
  ) u_proto (
    .mode     (mode0),
    .user     (in_user),
    .ctx      (in_ctx),
    .ea_seg   (in_ea_seg),
    .proto    (proto0),
    .reserved (rsv0)
  );

  vsid_mul_stage #(
    .NB_S(NB_S), .MUL_W(MUL_W), .MUL_S(MUL_S), .MUL_L(MUL_L)
  ) u_mul (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .v_i     (accept),
    .mode_i  (mode0),
    .err_i   (rsv0),
    .proto_i (proto0),
    .v_o     (v1),
    .mode_o  (mode1),
    .err_o   (err1),
    .prod_o  (prod1)
  );

  vsid_fold_stage #(
    .NB_S(NB_S), .NB_L(NB_L), .MUL_W(MUL_W)
  ) u_fold (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .v_i    (v1),
    .mode_i (mode1),
    .err_i  (err1),
    .prod_i (prod1),
    .v_o    (v2),
    .mode_o (mode2),
    .err_o  (err2),
    .fold_o (fold2)
  );

  vsid_fix_stage #(
    .NB_S(NB_S), .NB_L(NB_L)
  ) u_fix (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .v_i    (v2),
    .mode_i (mode2),
    .err_i  (err2),
    .fold_i (fold2),
    .v_o    (v3),
    .mode_o (mode3),
    .err_o  (err3),
    .vsid_o (vsid3)
  );

  assign out_valid = v3;
  assign out_err   = v3 & err3;
  assign out_vsid  = vsid3;

endmodule

// File: rtl/vsid_scrambler_chk.sv
`timescale 1ns/1ps
module vsid_scrambler_chk #(
  parameter int unsigned NB_S  = 36,
  parameter int unsigned NB_L  = 24,
  parameter int unsigned MUL_W = 28,
  localparam int unsigned FOLD_W = NB_S + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_err,
  input logic [NB_S-1:0]   out_vsid,
  input logic              v2,
  input logic              mode2,
  input logic [FOLD_W-1:0] fold2,
  input logic              mode3
);

  localparam logic [NB_S-1:0]   ONES_S = {NB_S{1'b1}};
  localparam logic [NB_S-1:0]   ONES_L = NB_S'({NB_L{1'b1}});
  localparam logic [FOLD_W-1:0] BND_S  = FOLD_W'((64'd1 << NB_S) + (64'd1 << MUL_W) - 64'd2);
  localparam logic [FOLD_W-1:0] BND_L  = FOLD_W'(64'd1 << (NB_L + 1));

  // R1: nothing is offered or produced while reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!in_ready && !out_valid && !out_err));

  // R7 / R9: a result appears exactly three edges after each accepted input
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid && in_ready, 3));

  // R8: an error result carries zero
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_vsid == '0));

  // R8: the reserved all-ones value never leaves the block
  p_no_reserved_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vsid != (mode3 ? ONES_L : ONES_S)));

  // R3: large-segment results fit the narrow width
  p_narrow_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode3) |-> (out_vsid[NB_S-1:NB_L] == '0));

  // R2: the single fold leaves a value a single carry step can finish
  p_fold_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (mode2 ? (fold2 < BND_L) : (fold2 < BND_S)));

endmodule

bind vsid_scrambler vsid_scrambler_chk #(
  .NB_S(NB_S), .NB_L(NB_L), .MUL_W(MUL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_err   (out_err),
  .out_vsid  (out_vsid),
  .v2        (v2),
  .mode2     (mode2),
  .fold2     (fold2),
  .mode3     (mode3)
);

// File: tb/vsid_scrambler_tb.sv
`timescale 1ns/1ps
module vsid_scrambler_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mode = 1'b0;
  logic        in_user = 1'b0;
  logic [18:0] in_ctx = '0;
  logic [35:0] in_ea_seg = '0;
  logic        out_valid;
  logic        out_err;
  logic [35:0] out_vsid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // expectation pipeline, slot 2 is due at the current negedge
  logic        exp_v   [3];
  logic        exp_e   [3];
  logic [35:0] exp_r   [3];
  string       exp_tag [3];

  always #2.5 clk = ~clk;

  vsid_scrambler u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_user(in_user), .in_ctx(in_ctx), .in_ea_seg(in_ea_seg),
    .out_valid(out_valid), .out_err(out_err), .out_vsid(out_vsid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: true modulo of the full product, proto built from R4-R6
  function automatic logic [36:0] model(input logic m, input logic u,
                                        input logic [18:0] c, input logic [35:0] s);
    logic [63:0] proto, mask, mul, prod;
    if (!m) begin
      mask  = (64'd1 << 36) - 64'd1;
      mul   = 64'd200730139;
      proto = u ? ((64'(c) << 16) | (64'(s) & 64'hFFFF)) : 64'(s);
    end else begin
      mask  = (64'd1 << 24) - 64'd1;
      mul   = 64'd12538073;
      proto = u ? ((64'(c) << 4) | ((64'(s) >> 12) & 64'hF)) : (64'(s) >> 12);
    end
    proto = proto & mask;
    prod  = proto * mul;
    model = {proto == mask, 36'(prod % mask)};
  endfunction

  task automatic step(input logic v, input logic m, input logic u,
                      input logic [18:0] c, input logic [35:0] s, input string tag);
    logic [36:0] r;
    @(negedge clk);
    if (exp_v[2]) begin
      chk(out_valid === 1'b1, {exp_tag[2], " R7 valid"}, 64'(out_valid), 64'd1);
      chk(out_vsid === exp_r[2], exp_tag[2], 64'(out_vsid), 64'(exp_r[2]));
      chk(out_err === exp_e[2], {exp_tag[2], " R8 err"}, 64'(out_err), 64'(exp_e[2]));
    end else begin
      chk(out_valid === 1'b0, {exp_tag[2], " R9 idle"}, 64'(out_valid), 64'd0);
    end
    for (int i = 2; i > 0; i--) begin
      exp_v[i] = exp_v[i-1]; exp_e[i] = exp_e[i-1];
      exp_r[i] = exp_r[i-1]; exp_tag[i] = exp_tag[i-1];
    end
    r = model(m, u, c, s);
    exp_v[0] = v && in_ready;
    exp_e[0] = r[36];
    exp_r[0] = r[35:0];
    exp_tag[0] = tag;
    in_valid = v; in_mode = m; in_user = u; in_ctx = c; in_ea_seg = s;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, '0, '0, "R9 drain");
  endtask

  task automatic t_reset();
    int waitn;
    for (int i = 0; i < 3; i++) begin
      exp_v[i] = 1'b0; exp_e[i] = 1'b0; exp_r[i] = '0; exp_tag[i] = "R9 reset";
    end
    in_valid = 1'b1;
    in_ea_seg = '1;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    chk(out_err === 1'b0, "R1 out_err in reset", 64'(out_err), 64'd0);
    chk(in_ready === 1'b0, "R1 in_ready in reset", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    waitn = 0;
    while (!in_ready && waitn < 5) begin
      @(negedge clk);
      waitn++;
      // R9: in_valid held high while not ready is never taken
      chk(out_valid === 1'b0, "R9 valid while not ready", 64'(out_valid), 64'd0);
    end
    chk(in_ready === 1'b1 && waitn <= 3, "R1 ready after release", 64'(waitn), 64'd3);
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, '0, '0, "R9 not ready");
  endtask

  task automatic t_kernel_small();
    step(1'b1, 1'b0, 1'b0, '0, 36'h0, "R2 zero");
    step(1'b1, 1'b0, 1'b0, '0, 36'h1, "R2 one");
    step(1'b1, 1'b0, 1'b0, '0, 36'hFFFFFFFFE, "R2 top-1");
    step(1'b1, 1'b0, 1'b0, '0, 36'h123456789, "R2 pattern");
    step(1'b1, 1'b0, 1'b0, 19'h7FFFF, 36'hC00000001, "R6 ctx ignored small");
    drain();
  endtask

  task automatic t_kernel_large();
    step(1'b1, 1'b1, 1'b0, '0, 36'h000001000, "R3 one");
    step(1'b1, 1'b1, 1'b0, '0, 36'hFFFFFE000, "R3 top-1");
    step(1'b1, 1'b1, 1'b0, 19'h2AAAA, 36'hABCDEF123, "R6 ctx and low bits ignored large");
    step(1'b1, 1'b1, 1'b0, '0, 36'h800000FFF, "R3 pattern");
    drain();
  endtask

  task automatic t_user();
    step(1'b1, 1'b0, 1'b1, 19'h12345, 36'h00000BEEF, "R4 user small");
    step(1'b1, 1'b0, 1'b1, 19'h12345, 36'hFFFFFBEEF, "R4 upper seg bits ignored");
    step(1'b1, 1'b0, 1'b1, 19'h7FFFF, 36'hFFFFFFFFF, "R8 user max not reserved");
    step(1'b1, 1'b1, 1'b1, 19'h00001, 36'h00000A000, "R5 user large");
    step(1'b1, 1'b1, 1'b1, 19'h7FFFF, 36'hFFFFF5FFF, "R5 user large mixed");
    drain();
  endtask

  task automatic t_reserved();
    step(1'b1, 1'b0, 1'b0, '0, 36'hFFFFFFFFF, "R8 reserved small");
    step(1'b1, 1'b1, 1'b0, '0, 36'hFFFFFF000, "R8 reserved large");
    step(1'b1, 1'b1, 1'b0, '0, 36'hFFFFFFFFF, "R8 reserved large low bits set");
    drain();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 24; i++) begin
      logic [35:0] s;
      s = 36'(64'h9E3779B97F4A7C15 * 64'(i + 1));
      if (i % 7 == 5)
        step(1'b0, 1'b0, 1'b0, '0, s, "R9 gap");
      else
        step(1'b1, 1'(i % 2), 1'(i % 3 == 0), 19'(i * 4099), s, "R7 stream");
    end
    drain();
  endtask

  initial begin
    t_reset();
    t_kernel_small();
    t_kernel_large();
    t_user();
    t_reserved();
    t_stream();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule